// File: doc/BRIEF.md
# Eight-Bit Lookahead Priority Slice

This block resolves priority across one eight-bit slice of a wide first-set-bit encoder. Bit 0 wins over every other bit. A lookahead input tells the slice that some slice of higher priority has already claimed the grant. The slice then forms a one-hot grant for its own lowest set bit and a lookahead output that it passes on to the slices of lower priority.

The slice is split into two four-bit nibbles. The incoming lookahead blocks the lower nibble. An internal nibble lookahead blocks the upper nibble. That internal lookahead is the OR of the incoming lookahead and the lower nibble's data, so neither half waits on a bit-by-bit chain through the other. The slice with the highest priority ties its lookahead input to 0.

The resolving logic is combinational. A thin clocked wrapper registers the grant and the lookahead output, so every result appears one cycle after its inputs are sampled.

Top module: `prio_slice8`

## Requirements
- R1: `laOut` equals the OR of `laIn` and all eight `dataIn` bits, as sampled at the previous rising clock edge.
- R2: For k in 0..3, `grantOut[k]` is 1 exactly when `dataIn[k]` is 1, `dataIn[k-1:0]` is all zero, and `laIn` is 0.
- R3: For k in 4..7, `grantOut[k]` is 1 exactly when `dataIn[k]` is 1, `dataIn[k-1:4]` is all zero, and the nibble lookahead (`laIn` OR any of `dataIn[3:0]`) is 0.
- R4: Whenever `laIn` was 1 at the sampling edge, `grantOut` is all zero, whatever the data.
- R5: At most one bit of `grantOut` is 1, and a grant bit is never 1 unless the matching data bit was 1.
- R6: When `dataIn` is all zero and `laIn` is 0, both `grantOut` and `laOut` are 0.
- R7: While `rstN` is low (active-low, asynchronous), `grantOut` and `laOut` read 0.
- R8: The outputs change only at a rising edge and reflect the inputs sampled at that edge. A change of input between edges leaves the outputs as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 8 | Request bits; bit 0 has the highest priority |
| laIn | input | 1 | Lookahead from the slices of higher priority; 1 blocks every grant |
| grantOut | output | 8 | Registered one-hot grant for the lowest set request bit |
| laOut | output | 1 | Registered lookahead passed to the slices of lower priority |

## Verification
All 256 data patterns are applied with both values of the lookahead input. The patterns whose lowest set bit lies in the lower nibble test the direct gating by the incoming lookahead. The patterns whose lower nibble is empty test the internal nibble lookahead alone. The all-zero pattern shows that an idle slice grants nothing and passes on no lookahead. Random sequences of inputs, applied back to back, expose any state carried from one cycle to the next. A directed change of input between clock edges separates the registered timing from a combinational path.

// File: rtl/prio_slice8_pkg.sv
package prio_slice8_pkg;
  localparam int SLICE_W = 8;
  localparam int NIB_W   = 4;
  localparam int NUM_NIB = SLICE_W / NIB_W;

  // One strobe per nibble: 1 means a higher-priority source already claimed the grant
  typedef struct packed {
    logic [NUM_NIB-1:0] nibBlock;
  } nibStrobes_t;
endpackage

// File: rtl/prio_slice8_ctrl.sv
module prio_slice8_ctrl
  import prio_slice8_pkg::*;
(
  input  logic [SLICE_W-1:0] dataIn,
  input  logic               laIn,
  output nibStrobes_t        strobes,
  output logic               laOut
);
  logic [NUM_NIB-1:0] nibAny;
  logic [NUM_NIB:0]   laChain;

  // Each nibble reduces its own data bits in parallel
  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nibAny
    assign nibAny[n] = |dataIn[n*NIB_W +: NIB_W];
  end

  // The lookahead into each nibble is the incoming lookahead ORed with every nibble below it
  assign laChain[0] = laIn;
  for (genvar n = 0; n < NUM_NIB; n++) begin : g_chain
    assign laChain[n+1] = laChain[n] | nibAny[n];
  end

  assign strobes.nibBlock = laChain[NUM_NIB-1:0];
  assign laOut            = laChain[NUM_NIB];
endmodule

// File: rtl/prio_slice8_dp.sv
module prio_slice8_dp
  import prio_slice8_pkg::*;
(
  input  logic [SLICE_W-1:0] dataIn,
  input  nibStrobes_t        strobes,
  output logic [SLICE_W-1:0] grant
);
  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    logic [NIB_W-1:0] nibData;
    assign nibData = dataIn[n*NIB_W +: NIB_W];
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      // Bits below b inside this nibble
      localparam logic [NIB_W-1:0] LowerMask = NIB_W'((1 << b) - 1);
      assign grant[n*NIB_W + b] = nibData[b] & ~strobes.nibBlock[n]
                                  & ~(|(nibData & LowerMask));
    end
  end
endmodule

// File: rtl/prio_slice8.sv
module prio_slice8
  import prio_slice8_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SLICE_W-1:0] dataIn,
  input  logic               laIn,
  output logic [SLICE_W-1:0] grantOut,
  output logic               laOut
);
  nibStrobes_t        strobes;
  logic [SLICE_W-1:0] grantComb;
  logic               laOutComb;

  prio_slice8_ctrl u_ctrl (
    .dataIn  (dataIn),
    .laIn    (laIn),
    .strobes (strobes),
    .laOut   (laOutComb)
  );

  prio_slice8_dp u_dp (
    .dataIn  (dataIn),
    .strobes (strobes),
    .grant   (grantComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOut <= '0;
      laOut    <= 1'b0;
    end else begin
      grantOut <= grantComb;
      laOut    <= laOutComb;
    end
  end
endmodule

// File: rtl/prio_slice8_chk.sv
module prio_slice8_chk
  import prio_slice8_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [SLICE_W-1:0] dataIn,
  input logic               laIn,
  input logic [SLICE_W-1:0] grantOut,
  input logic               laOut
);
  // Set once one edge out of reset has loaded the output registers
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut)); // R5

  AST_GRANT_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((grantOut & ~$past(dataIn)) == '0)); // R5

  AST_LA_IN_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(laIn)) |-> (grantOut == '0)); // R4

  AST_LA_OUT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (laOut == ($past(laIn) | (|$past(dataIn))))); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(laIn) && ($past(dataIn) == '0)) |-> (!laOut && grantOut == '0)); // R6

  AST_GRANT_IMPLIES_LA: assert property (@(posedge clk) disable iff (!rstN)
    (|grantOut) |-> laOut); // R1
endmodule

bind prio_slice8 prio_slice8_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dataIn   (dataIn),
  .laIn     (laIn),
  .grantOut (grantOut),
  .laOut    (laOut)
);

// File: tb/prio_slice8_tb.sv
`timescale 1ns/1ps
module prio_slice8_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       laIn = 1'b0;
  logic [7:0] grantOut;
  logic       laOut;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  prio_slice8 u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .laIn     (laIn),
    .grantOut (grantOut),
    .laOut    (laOut)
  );

  // Reference: one-hot of the lowest set bit, unless blocked from above
  function automatic logic [7:0] refGrant(logic [7:0] d, logic la);
    if (la) return 8'h00;
    for (int i = 0; i < 8; i++) if (d[i]) return 8'(1 << i);
    return 8'h00;
  endfunction

  function automatic logic refLa(logic [7:0] d, logic la);
    return la | (|d);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Tag the grant check by which rule decides it
  function automatic string grantTag(logic [7:0] d, logic la);
    if (la)             return "R4 blocked by laIn";
    if (d == 8'h00)     return "R6 idle grant";
    if (d[3:0] != 4'h0) return "R2 lower nibble";
    return "R3 upper nibble";
  endfunction

  task automatic applyAndCheck(logic [7:0] d, logic la);
    @(negedge clk);
    dataIn = d;
    laIn   = la;
    @(posedge clk);
    #1;
    chk(grantTag(d, la), grantOut, refGrant(d, la));
    chk((d == 8'h00 && !la) ? "R6 idle laOut" : "R1 laOut", {7'd0, laOut}, {7'd0, refLa(d, la)});
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R7: reset holds the outputs low even with an active request
    dataIn = 8'h01;
    laIn   = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 reset grant", grantOut, 8'h00);
    chk("R7 reset laOut", {7'd0, laOut}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // Exhaustive sweep: every data pattern with both lookahead values
    for (int la = 0; la < 2; la++) begin
      for (int d = 0; d < 256; d++) begin
        applyAndCheck(8'(d), la[0]);
      end
    end

    // Directed corners
    applyAndCheck(8'hFF, 1'b0);  // R2: bit 0 wins over all
    applyAndCheck(8'hF0, 1'b0);  // R3: bit 4 wins with empty lower nibble
    applyAndCheck(8'h80, 1'b0);  // R3: lowest priority bit alone
    applyAndCheck(8'h88, 1'b0);  // R2: bit 3 blocks the upper nibble
    applyAndCheck(8'h80, 1'b1);  // R4
    applyAndCheck(8'h00, 1'b1);  // R1: laOut from laIn alone

    // R8: a change between edges leaves the outputs alone
    applyAndCheck(8'h04, 1'b0);
    @(negedge clk);
    dataIn = 8'h40;
    #2;
    chk("R8 hold grant", grantOut, 8'h04);
    @(posedge clk);
    #1;
    chk("R8 update grant", grantOut, 8'h40);

    // Random sequences, back to back
    for (int i = 0; i < 400; i++) begin
      logic [7:0] rd;
      logic       rl;
      rd = 8'($urandom);
      if ((i % 3) == 0) rd = rd & 8'($urandom);  // sparser patterns
      rl = ($urandom % 4) == 0;
      applyAndCheck(rd, rl);
    end

    // R7: asynchronous reset in mid run
    applyAndCheck(8'h02, 1'b0);
    #2;
    rstN = 1'b0;
    #1;
    chk("R7 async reset grant", grantOut, 8'h00);
    chk("R7 async reset laOut", {7'd0, laOut}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule